// File: doc/BRIEF.md
# System bus access engine

This unit lets an external debugger reach memory and peripherals on the system bus without involving the processor. The debugger talks to three small registers: control, address and data. Reads and writes of these registers turn into single transfers on a valid/ready bus master port. A separate bridge may convert that port to another bus. Transfers can be byte, halfword or word wide. A transfer can be started in three ways: writing the address register (when read-on-address is enabled), writing the data register (always a bus write), or reading the data register (when read-on-data is enabled). After each successful transfer the address can optionally step forward by the access size.

Error handling is deliberately strict. The alignment check always uses the address that the transfer will actually use, including an address being written in that same cycle. No transfer starts while an error or busy-error flag is pending. A transfer that returns a bus error leaves the data register untouched. For sub-word accesses, write data is copied onto every byte lane, and read data is taken from the addressed lane and moved down to the low bits.

The whole unit sits behind a build parameter that is off by default. When it is off, the bus port stays idle and every register reads as zero.

Top module: `sba_engine`

## Requirements
- R1: With `SBA_EN` at its default of 0, `bus_valid` never rises and every debugger register read returns 0.
- R2: When enabled, the control register reads 0x8000_0200 after reset. Its layout is: err[2:0], busy-error[3], busy[4], read-on-address[5], read-on-data[6], auto-increment[7], size[10:8] (0 byte, 1 halfword, 2 word) and present[31]. Register select codes on `dbg_sel` are 0 control, 1 address, 2 data. A read returns its value on `dbg_rdata` after the clock edge that accepts it.
- R3: The alignment check uses the address being written in that cycle when a transfer is triggered by an address write. A misaligned address sets err to 3 and starts no transfer, but the address register still takes the written value.
- R4: A size code above 2 sets err to 4 on a triggering access and starts no transfer.
- R5: No transfer starts while err is non-zero or busy-error is set.
- R6: A transfer that completes with `bus_err` sets err to 2 and leaves the data register unchanged.
- R7: A bus write places the data byte on all four lanes for size 0, and the low halfword on both halves for size 1.
- R8: A bus read loads the data register with the addressed byte or halfword, zero-extended from bit 0. A word read loads the whole word.
- R9: With auto-increment on, the address register advances by 1, 2 or 4 after each successful transfer, and does not move after a failed one.
- R10: With read-on-data on, a data read returns the value held before the access, then starts a bus read at the current address.
- R11: An access to the address or data register while a transfer is outstanding sets busy-error and is otherwise ignored.
- R12: Writing 1s to err bits or to the busy-error bit clears them. A bus error arriving in the same cycle as such a clear wins, leaving err at 2.
- R13: `bus_valid` stays high, with address, size, direction and write data stable, until `bus_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_req | input | 1 | Debugger register access strobe, one cycle per access |
| dbg_wr | input | 1 | Access is a write |
| dbg_sel | input | 2 | Register select: 0 control, 1 address, 2 data |
| dbg_wdata | input | DATA_W | Debugger write value |
| dbg_rdata | output | DATA_W | Registered read value |
| bus_valid | output | 1 | Transfer request |
| bus_write | output | 1 | Transfer is a write |
| bus_addr | output | ADDR_W | Byte address |
| bus_size | output | 2 | log2 of the access size in bytes |
| bus_wdata | output | DATA_W | Lane-replicated write data |
| bus_ready | input | 1 | Transfer accepted and completed this cycle |
| bus_rdata | input | DATA_W | Read data, valid with bus_ready |
| bus_err | input | 1 | Transfer failed, valid with bus_ready |

## Verification
The tricky overlap is a bus completion that reports an error in the same cycle as a debugger write that clears the error field. The bench holds `bus_ready` low on a read aimed at the faulting region. It then releases `bus_ready` in exactly the cycle in which the control write carrying the clear bits is presented. The result is judged by reading control afterwards: err must show 2, not 0. A second overlap is an address-register access that arrives while a transfer is still waiting for `bus_ready`. Here the bench checks that busy-error is set and that the address register and the completed read are unaffected.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_BUS   = 3'd2;
  localparam logic [2:0] ERR_ALIGN = 3'd3;
  localparam logic [2:0] ERR_SIZE  = 3'd4;

  localparam logic [2:0] SIZE_RESET = 3'd2;

  typedef struct packed {
    logic [2:0] size;
    logic       autoinc;
    logic       rd_on_data;
    logic       rd_on_addr;
  } sba_cfg_t;
endpackage

// File: rtl/sba_access_check.sv
module sba_access_check
  import sba_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic [2:0]       size,
  input  logic [OFF_W-1:0] offset,
  output logic [2:0]       code
);
  logic [OFF_W-1:0] low_mask;

  always_comb begin
    low_mask = OFF_W'((1 << size) - 1);
    if (int'(size) > OFF_W)
      code = ERR_SIZE;
    else if ((offset & low_mask) != '0)
      code = ERR_ALIGN;
    else
      code = ERR_NONE;
  end
endmodule

// File: rtl/sba_lane_steer.sv
module sba_lane_steer #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2
) (
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] wr_rep,
  input  logic [1:0]        rd_size,
  input  logic [OFF_W-1:0]  rd_offset,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] rd_pick
);
  localparam int LANES = DATA_W / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] lane_v;
    always_comb begin
      case (wr_size)
        2'd0:    lane_v = wr_data[7:0];
        2'd1:    lane_v = wr_data[8*(i%2) +: 8];
        default: lane_v = wr_data[8*i +: 8];
      endcase
    end
    assign wr_rep[8*i +: 8] = lane_v;
  end

  logic [DATA_W-1:0] shifted;
  assign shifted = rd_data >> {rd_offset, 3'b000};

  always_comb begin
    case (rd_size)
      2'd0:    rd_pick = DATA_W'(shifted[7:0]);
      2'd1:    rd_pick = DATA_W'(shifted[15:0]);
      default: rd_pick = shifted;
    endcase
  end
endmodule

// File: rtl/sba_bus_master.sv
module sba_bus_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_write,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [1:0]        start_size,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              bus_ready,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_size  <= '0;
      bus_wdata <= '0;
    end else if (start) begin
      bus_valid <= 1'b1;
      bus_write <= start_write;
      bus_addr  <= start_addr;
      bus_size  <= start_size;
      bus_wdata <= start_wdata;
    end else if (bus_valid && bus_ready) begin
      bus_valid <= 1'b0;
    end
  end

  // R13: request held steady until accepted
  a_r13_hold_request: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_size)
                                   && $stable(bus_write) && $stable(bus_wdata)));

  // R3: only aligned requests ever reach the bus
  a_r3_aligned_on_bus: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> ((bus_addr & ((ADDR_W'(1) << bus_size) - ADDR_W'(1))) == '0));

  // R11: no second start while one is outstanding
  a_r11_no_restart: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |-> !start);
endmodule

// File: rtl/sba_engine.sv
module sba_engine
  import sba_pkg::*;
#(
  parameter bit SBA_EN = 1'b0,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_req,
  input  logic              dbg_wr,
  input  logic [1:0]        dbg_sel,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int PAD_W = DATA_W - 12;

  if (SBA_EN) begin : g_on
    sba_cfg_t          cfg_q;
    logic [2:0]        err_q;
    logic              busyerr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] rdata_q;

    logic busy, done, wr_ctrl, hit_addr, hit_data, blocked;
    logic wr_addr, wr_data, rd_data, want, start, chk_fail;
    logic [ADDR_W-1:0] xfer_addr, step;
    logic [2:0]        chk_code;
    logic [DATA_W-1:0] rep_wdata, pick_rdata, ctrl_word;

    assign busy     = bus_valid;
    assign done     = bus_valid & bus_ready;
    assign wr_ctrl  = dbg_req & dbg_wr & (dbg_sel == SEL_CTRL);
    assign hit_addr = dbg_req & (dbg_sel == SEL_ADDR);
    assign hit_data = dbg_req & (dbg_sel == SEL_DATA);
    assign blocked  = (hit_addr | hit_data) & busy;
    assign wr_addr  = hit_addr & dbg_wr & ~busy;
    assign wr_data  = hit_data & dbg_wr & ~busy;
    assign rd_data  = hit_data & ~dbg_wr & ~busy;

    assign want = ((wr_addr & cfg_q.rd_on_addr) | wr_data | (rd_data & cfg_q.rd_on_data))
                  & (err_q == ERR_NONE) & ~busyerr_q;
    assign xfer_addr = wr_addr ? dbg_wdata[ADDR_W-1:0] : addr_q;
    assign start     = want & (chk_code == ERR_NONE);
    assign chk_fail  = want & (chk_code != ERR_NONE);
    assign step      = ADDR_W'(1) << bus_size;

    assign ctrl_word = {1'b1, {PAD_W{1'b0}}, cfg_q.size, cfg_q.autoinc, cfg_q.rd_on_data,
                        cfg_q.rd_on_addr, busy, busyerr_q, err_q};

    sba_access_check #(.OFF_W(OFF_W)) u_check (
      .size   (cfg_q.size),
      .offset (xfer_addr[OFF_W-1:0]),
      .code   (chk_code)
    );

    sba_lane_steer #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_steer (
      .wr_size   (cfg_q.size[1:0]),
      .wr_data   (dbg_wdata),
      .wr_rep    (rep_wdata),
      .rd_size   (bus_size),
      .rd_offset (bus_addr[OFF_W-1:0]),
      .rd_data   (bus_rdata),
      .rd_pick   (pick_rdata)
    );

    sba_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_master (
      .clk         (clk),
      .rst         (rst),
      .start       (start),
      .start_write (wr_data),
      .start_addr  (xfer_addr),
      .start_size  (cfg_q.size[1:0]),
      .start_wdata (rep_wdata),
      .bus_ready   (bus_ready),
      .bus_valid   (bus_valid),
      .bus_write   (bus_write),
      .bus_addr    (bus_addr),
      .bus_size    (bus_size),
      .bus_wdata   (bus_wdata)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q     <= '{size: SIZE_RESET, autoinc: 1'b0, rd_on_data: 1'b0, rd_on_addr: 1'b0};
        err_q     <= ERR_NONE;
        busyerr_q <= 1'b0;
        addr_q    <= '0;
        data_q    <= '0;
        rdata_q   <= '0;
      end else begin
        if (wr_ctrl)
          cfg_q <= '{size: dbg_wdata[10:8], autoinc: dbg_wdata[7],
                     rd_on_data: dbg_wdata[6], rd_on_addr: dbg_wdata[5]};

        if (done && bus_err)
          err_q <= ERR_BUS;
        else if (chk_fail)
          err_q <= chk_code;
        else if (wr_ctrl)
          err_q <= err_q & ~dbg_wdata[2:0];

        if (blocked)
          busyerr_q <= 1'b1;
        else if (wr_ctrl && dbg_wdata[3])
          busyerr_q <= 1'b0;

        if (wr_addr)
          addr_q <= dbg_wdata[ADDR_W-1:0];
        else if (done && !bus_err && cfg_q.autoinc)
          addr_q <= addr_q + step;

        if (wr_data)
          data_q <= dbg_wdata;
        else if (done && !bus_err && !bus_write)
          data_q <= pick_rdata;

        if (dbg_req && !dbg_wr) begin
          case (dbg_sel)
            SEL_CTRL: rdata_q <= ctrl_word;
            SEL_ADDR: rdata_q <= DATA_W'(addr_q);
            SEL_DATA: rdata_q <= data_q;
            default:  rdata_q <= '0;
          endcase
        end
      end
    end

    assign dbg_rdata = rdata_q;

    // R5: a request only rises when no error was pending
    a_r5_quiet_on_error: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_valid) |-> ($past(err_q) == ERR_NONE && !$past(busyerr_q)));

    // R6: failed completion flags bus error and keeps data
    a_r6_fail_keeps_data: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && bus_ready && bus_err) |=> (err_q == ERR_BUS && $stable(data_q)));

    // R11: address access during a transfer is dropped
    a_r11_busy_addr_dropped: assert property (@(posedge clk) disable iff (rst)
      (dbg_req && dbg_sel == SEL_ADDR && bus_valid && !bus_ready)
        |=> (busyerr_q && $stable(addr_q)));

    // R12: error set outranks the clear in the same cycle
    a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && bus_ready && bus_err && wr_ctrl) |=> (err_q == ERR_BUS));
  end else begin : g_off
    logic unused_inputs;
    assign unused_inputs = ^{clk, rst, dbg_req, dbg_wr, dbg_sel, dbg_wdata,
                             bus_ready, bus_rdata, bus_err};
    assign dbg_rdata = '0;
    assign bus_valid = 1'b0;
    assign bus_write = 1'b0;
    assign bus_addr  = '0;
    assign bus_size  = '0;
    assign bus_wdata = '0;
  end
endmodule

// File: tb/sba_engine_test.sv
module sba_engine_test;
  localparam logic [1:0] S_CTRL = 2'd0, S_ADDR = 2'd1, S_DATA = 2'd2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, wr = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, bus_addr, bus_wdata, bus_rdata;
  logic        bus_valid, bus_write, bus_ready, bus_err;
  logic [1:0]  bus_size;
  logic [31:0] rdata_off, ba_off, bwd_off;
  logic        bv_off, bw_off;
  logic [1:0]  bs_off;

  logic hold_low = 1'b0, force_hi = 1'b0, rdy_rand = 1'b0;
  int   n_cmp = 0, n_bad = 0, xfer_cnt = 0;
  logic off_seen = 1'b0;
  logic [31:0] lg_addr = '0, lg_wdata = '0;
  logic [1:0]  lg_size = '0;
  logic        lg_wr = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return (w * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction

  assign bus_rdata = mem_word(bus_addr);
  assign bus_err   = (bus_addr[31:28] == 4'hE);
  assign bus_ready = hold_low ? 1'b0 : (force_hi ? 1'b1 : rdy_rand);

  sba_engine #(.SBA_EN(1'b1)) uut (
    .clk(clk), .rst(rst), .dbg_req(req), .dbg_wr(wr), .dbg_sel(sel), .dbg_wdata(wdata),
    .dbg_rdata(rdata), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .bus_err(bus_err));

  sba_engine uut_off (
    .clk(clk), .rst(rst), .dbg_req(req), .dbg_wr(wr), .dbg_sel(sel), .dbg_wdata(wdata),
    .dbg_rdata(rdata_off), .bus_valid(bv_off), .bus_write(bw_off), .bus_addr(ba_off),
    .bus_size(bs_off), .bus_wdata(bwd_off), .bus_ready(1'b1),
    .bus_rdata(32'h1234_5678), .bus_err(1'b0));

  always @(negedge clk) rdy_rand <= ($urandom % 3) != 0;

  always @(posedge clk) begin
    if (bv_off) off_seen <= 1'b1;
    if (bus_valid && bus_ready) begin
      xfer_cnt <= xfer_cnt + 1;
      lg_addr  <= bus_addr;
      lg_wdata <= bus_wdata;
      lg_size  <= bus_size;
      lg_wr    <= bus_write;
    end
  end

  function automatic logic [31:0] cfg(input int sz, input bit ra, input bit rd, input bit ai);
    return (32'(sz) << 8) | (32'(ai) << 7) | (32'(rd) << 6) | (32'(ra) << 5);
  endfunction

  function automatic logic [2:0] exp_code(input logic [31:0] a, input int sz);
    if (sz > 2) return 3'd4;
    if ((a & ((32'd1 << sz) - 1)) != 0) return 3'd3;
    return 3'd0;
  endfunction

  function automatic logic [31:0] exp_rep(input logic [31:0] d, input int sz);
    if (sz == 0) return {4{d[7:0]}};
    if (sz == 1) return {2{d[15:0]}};
    return d;
  endfunction

  function automatic logic [31:0] exp_pick(input logic [31:0] a, input int sz);
    logic [31:0] s;
    s = mem_word(a) >> (8 * a[1:0]);
    if (sz == 0) return {24'd0, s[7:0]};
    if (sz == 1) return {16'd0, s[15:0]};
    return s;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic dbg_write(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk);
    req = 1'b1; wr = 1'b1; sel = s; wdata = v;
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
  endtask

  task automatic dbg_read(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    req = 1'b1; wr = 1'b0; sel = s;
    @(negedge clk);
    req = 1'b0;
    v = rdata;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (bus_valid) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, cur_data, a, d, d0;
    int n0, sz;
    logic [2:0] code;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R2 reset state, R1 disabled instance
    dbg_read(S_CTRL, v);
    chk("R2 ctrl reset", v, 32'h8000_0200);
    chk("R1 off ctrl reads zero", rdata_off, 32'h0);
    dbg_read(S_ADDR, v);
    chk("R2 addr reset", v, 32'h0);
    chk("R1 off addr reads zero", rdata_off, 32'h0);

    cur_data = 32'h0;
    for (int it = 0; it < 40; it++) begin
      sz = int'($urandom % 3);
      a = $urandom & 32'h0000_0FFF;
      if ($urandom % 6 == 0) a = a | 32'hE000_0000;
      d = $urandom;
      code = exp_code(a, sz);
      if ($urandom % 2 == 0) begin
        dbg_write(S_CTRL, cfg(sz, 1, 0, 0));
        n0 = xfer_cnt;
        dbg_write(S_ADDR, a);
        wait_idle();
        if (code == 3'd0) begin
          n0 = n0 + 1;
          if (a[31:28] == 4'hE) code = 3'd2;
          else cur_data = exp_pick(a, sz);
        end
        dbg_read(S_DATA, v);
        chk("R8 read lane pick", v, cur_data);
        chk("R3 read transfer count", 32'(xfer_cnt), 32'(n0));
      end else begin
        dbg_write(S_CTRL, cfg(sz, 0, 0, 0));
        dbg_write(S_ADDR, a);
        n0 = xfer_cnt;
        dbg_write(S_DATA, d);
        wait_idle();
        cur_data = d;
        if (code == 3'd0) begin
          chk("R7 write replication", lg_wdata, exp_rep(d, sz));
          chk("R7 write address", lg_addr, a);
          chk("R7 write count", 32'(xfer_cnt), 32'(n0 + 1));
          if (a[31:28] == 4'hE) code = 3'd2;
        end else begin
          chk("R3 misaligned write count", 32'(xfer_cnt), 32'(n0));
        end
      end
      dbg_read(S_CTRL, v);
      chk("R6 error field", {29'd0, v[2:0]}, {29'd0, code});
      dbg_write(S_CTRL, cfg(sz, 0, 0, 0) | 32'hF);
    end

    // R7 directed byte and halfword
    dbg_write(S_CTRL, cfg(0, 0, 0, 0));
    dbg_write(S_ADDR, 32'h103);
    dbg_write(S_DATA, 32'h1122_3344);
    wait_idle();
    chk("R7 byte lanes", lg_wdata, 32'h4444_4444);
    dbg_write(S_CTRL, cfg(1, 0, 0, 0));
    dbg_write(S_ADDR, 32'h102);
    dbg_write(S_DATA, 32'hAABB_CCDD);
    wait_idle();
    chk("R7 half lanes", lg_wdata, 32'hCCDD_CCDD);

    // R3 alignment uses the freshly written address
    dbg_write(S_CTRL, cfg(2, 1, 0, 0));
    n0 = xfer_cnt;
    dbg_write(S_ADDR, 32'h201);
    wait_idle();
    chk("R3 misaligned no transfer", 32'(xfer_cnt), 32'(n0));
    dbg_read(S_CTRL, v);
    chk("R3 align error", {29'd0, v[2:0]}, 32'd3);
    dbg_read(S_ADDR, v);
    chk("R3 address still written", v, 32'h201);
    dbg_write(S_CTRL, cfg(2, 1, 0, 0) | 32'h7);
    dbg_write(S_ADDR, 32'h300);
    wait_idle();
    chk("R3 fresh aligned address reads", 32'(xfer_cnt), 32'(n0 + 1));
    dbg_read(S_DATA, v);
    chk("R8 word read", v, mem_word(32'h300));

    // R4 unsupported size, then R5 with error pending
    dbg_write(S_CTRL, cfg(3, 0, 0, 0));
    n0 = xfer_cnt;
    dbg_write(S_DATA, 32'h55);
    wait_idle();
    dbg_read(S_CTRL, v);
    chk("R4 size error", {29'd0, v[2:0]}, 32'd4);
    dbg_write(S_CTRL, cfg(2, 0, 0, 0));
    dbg_write(S_DATA, 32'h66);
    wait_idle();
    chk("R5 no transfer with err set", 32'(xfer_cnt), 32'(n0));
    dbg_write(S_CTRL, cfg(2, 0, 0, 0) | 32'h7);

    // R11 busy access dropped; R5 with busy-error pending
    hold_low = 1'b1;
    dbg_write(S_CTRL, cfg(2, 1, 0, 0));
    dbg_write(S_ADDR, 32'h600);
    dbg_write(S_ADDR, 32'h700);
    hold_low = 1'b0;
    wait_idle();
    dbg_read(S_CTRL, v);
    chk("R11 busy error set", {31'd0, v[3]}, 32'd1);
    dbg_read(S_ADDR, v);
    chk("R11 address unchanged", v, 32'h600);
    dbg_read(S_DATA, v);
    chk("R11 pending read completes", v, mem_word(32'h600));
    n0 = xfer_cnt;
    dbg_write(S_DATA, 32'h77);
    wait_idle();
    chk("R5 no transfer with busy error", 32'(xfer_cnt), 32'(n0));
    dbg_write(S_CTRL, cfg(2, 0, 0, 0) | 32'h8);
    dbg_read(S_CTRL, v);
    chk("R12 busy error cleared", {31'd0, v[3]}, 32'd0);

    // R6 failed read keeps data
    dbg_read(S_DATA, d0);
    dbg_write(S_CTRL, cfg(2, 1, 0, 0));
    dbg_write(S_ADDR, 32'hE000_0040);
    wait_idle();
    dbg_read(S_DATA, v);
    chk("R6 data kept on bus error", v, d0);
    dbg_read(S_CTRL, v);
    chk("R6 bus error code", {29'd0, v[2:0]}, 32'd2);
    dbg_write(S_CTRL, cfg(2, 0, 0, 0) | 32'h7);
    dbg_read(S_CTRL, v);
    chk("R12 w1c clears err", {29'd0, v[2:0]}, 32'd0);

    // R12 bus error and clear in the same cycle
    hold_low = 1'b1;
    dbg_write(S_CTRL, cfg(2, 1, 0, 0));
    dbg_write(S_ADDR, 32'hE000_0080);
    @(negedge clk);
    hold_low = 1'b0; force_hi = 1'b1;
    req = 1'b1; wr = 1'b1; sel = S_CTRL; wdata = cfg(2, 0, 0, 0) | 32'h7;
    @(negedge clk);
    req = 1'b0; wr = 1'b0; force_hi = 1'b0;
    dbg_read(S_CTRL, v);
    chk("R12 set wins over clear", {29'd0, v[2:0]}, 32'd2);
    dbg_write(S_CTRL, cfg(2, 0, 0, 0) | 32'h7);

    // R9 auto-increment
    dbg_write(S_CTRL, cfg(1, 0, 0, 1));
    dbg_write(S_ADDR, 32'h400);
    dbg_write(S_DATA, 32'h1234);
    wait_idle();
    chk("R9 first address", lg_addr, 32'h400);
    dbg_write(S_DATA, 32'h5678);
    wait_idle();
    chk("R9 second address", lg_addr, 32'h402);
    dbg_read(S_ADDR, v);
    chk("R9 address advanced", v, 32'h404);
    dbg_write(S_ADDR, 32'hE000_0000);
    dbg_write(S_DATA, 32'h9);
    wait_idle();
    dbg_read(S_ADDR, v);
    chk("R9 no step after failure", v, 32'hE000_0000);
    dbg_write(S_CTRL, cfg(1, 0, 0, 0) | 32'h7);

    // R10 read-on-data
    dbg_write(S_CTRL, cfg(2, 0, 0, 0));
    dbg_read(S_DATA, d0);
    dbg_write(S_CTRL, cfg(2, 0, 1, 1));
    dbg_write(S_ADDR, 32'h500);
    dbg_read(S_DATA, v);
    chk("R10 returns previous value", v, d0);
    wait_idle();
    dbg_read(S_DATA, v);
    chk("R10 next read loaded", v, mem_word(32'h500));
    wait_idle();
    dbg_read(S_ADDR, v);
    chk("R10 address after two reads", v, 32'h508);

    chk("R1 off instance bus idle", {31'd0, off_seen}, 32'd0);
    dbg_read(S_DATA, v);
    chk("R1 off data reads zero", rdata_off, 32'h0);

    summary();
    $finish;
  end
endmodule